// File: doc/BRIEF.md
# Privileged Control-Register Access Unit

This unit executes the three control/status register instructions of a 64-bit in-order core: read, write and masked exchange. Each cycle it may take one instruction word with the core's current privilege level and the contents of the two source registers. The opcode byte selects the instruction group. A 14-bit field selects the register, and the rj field selects the operation. One cycle later the unit gives the value to write back to rd, any trap, and the side-effect pulses that the rest of the core acts on: a TLB flush, a timer-interrupt clear and a request to refetch from the next instruction.

The unit holds a small register file. It has a mode word, an extension-enable word, an exception status word, a bad-address register and an address-space identifier. It also has two page-directory bases (low and high half of the address space), a refill bad-address register and a refill return-address register. A group of scratch registers, a timer-interrupt acknowledge location and a few read-only words complete the file. The read-only words are a miscellaneous word, a core identifier, a feature word and a derived page-directory view. Every register index is a parameter.

Top module: `csr_access_unit`

## Requirements
- R1: Only a word with bits [31:24] = 8'h04 and instVld high is accepted. Any other word produces no resVld and changes no state.
- R2: An accepted instruction with userLevel high raises privTrap with wbEn low. It changes no register and raises no tlbFlush, timerClear or refetch.
- R3: An index that maps to no register reads as zero. A write or exchange to it is dropped, and rd receives zero.
- R4: A write or exchange (rj field not 0) to a read-only index raises illegalTrap with wbEn low and no state change. A read of that index returns its value. The read-only indices are the miscellaneous word, the core identifier, the feature word and the page-directory view.
- R5: rj field = 1 is a write. It stores rdVal and returns the previous register value.
- R6: rj field of 2 or more is an exchange. It stores (rdVal & rjVal) | (old & ~rjVal) and returns old.
- R7: Writes and exchanges to the exception status word change only bits [1:0]. The full old value is returned.
- R8: Writes and exchanges to the address-space identifier change only bits [9:0]. tlbFlush pulses only when the resulting value differs from the previous one.
- R9: A read of the page-directory view selects a faulting address. It takes the refill bad address when bit 0 of the refill return-address register is 1, and the bad-address register otherwise. It then returns the high base if bit 63 of that address is 1, and the low base otherwise.
- R10: A write or exchange to the timer-acknowledge index pulses timerClear when bit 0 of the stored value is 1. It always returns zero.
- R11: refetch pulses for a completed write or exchange to the mode, extension-enable, exception status or address-space registers, and for no other access.
- R12: Results appear on the cycle after the accepted instruction, back to back. Every output is a single-cycle pulse qualified by resVld, and all outputs are zero in cycles without a result.
- R13: After reset all outputs are zero, and the registers hold their parameter reset values (mode 64'h8, exception status 64'h00A5_0000, address-space identifier 64'h000A_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instVld | input | 1 | Instruction strobe |
| instWord | input | 32 | Instruction word |
| userLevel | input | 1 | Core runs at user privilege |
| rdVal | input | 64 | Contents of register rd |
| rjVal | input | 64 | Contents of register rj (exchange mask) |
| resVld | output | 1 | Result for an accepted instruction |
| wbEn | output | 1 | Write wbData to rd |
| wbReg | output | 5 | Destination register number |
| wbData | output | 64 | Write-back value |
| privTrap | output | 1 | Instruction-privilege exception |
| illegalTrap | output | 1 | Illegal-instruction exception |
| tlbFlush | output | 1 | Flush pulse on identifier change |
| timerClear | output | 1 | Timer interrupt clear pulse |
| refetch | output | 1 | Resume at next instruction |

## Verification
The bench targets the masked writes: an exception-status or identifier update that disturbed the protected bits would return the wrong old value on the next read. A flush raised on an unchanged identifier, or missed on an exchange that changes it, shows on tlbFlush. The page-directory view is driven through all four combinations of refill flag and address sign bit, so a mux on the wrong bit returns the other base. Trapped, undefined, one-past-the-scratch-group and foreign-opcode accesses are each followed by a read-back, so a dropped write that leaks into a register, or a pulse fired on a trapped access, shows up as a mismatch.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  localparam int OPC_LO    = 24;
  localparam int OPC_W     = 8;
  localparam int IDX_LO    = 10;
  localparam int RJ_LO     = 5;
  localparam int RD_LO     = 0;
  localparam int REG_W     = 5;
  localparam int SCR_SEL_W = 6;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_CRMD, TGT_EUEN, TGT_ESTAT, TGT_BADV, TGT_ASID,
    TGT_PGDL, TGT_PGDH, TGT_PGD, TGT_MISC, TGT_CPUID, TGT_CFG,
    TGT_TICLR, TGT_RBADV, TGT_RERA, TGT_SCR
  } csrTgt_e;

  typedef struct packed {
    logic                 go;
    logic                 commit;
    logic                 isXchg;
    csrTgt_e              tgt;
    logic [SCR_SEL_W-1:0] scrSel;
  } csrStb_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_unit_pkg::*;
#(
  parameter int               IDX_W     = 14,
  parameter int               NUM_SCR   = 8,
  parameter logic [7:0]       OPC       = 8'h04,
  parameter logic [IDX_W-1:0] IDX_CRMD  = 'h0,
  parameter logic [IDX_W-1:0] IDX_EUEN  = 'h2,
  parameter logic [IDX_W-1:0] IDX_MISC  = 'h3,
  parameter logic [IDX_W-1:0] IDX_ESTAT = 'h5,
  parameter logic [IDX_W-1:0] IDX_BADV  = 'h7,
  parameter logic [IDX_W-1:0] IDX_ASID  = 'h18,
  parameter logic [IDX_W-1:0] IDX_PGDL  = 'h19,
  parameter logic [IDX_W-1:0] IDX_PGDH  = 'h1a,
  parameter logic [IDX_W-1:0] IDX_PGD   = 'h1b,
  parameter logic [IDX_W-1:0] IDX_CPUID = 'h20,
  parameter logic [IDX_W-1:0] IDX_CFG   = 'h21,
  parameter logic [IDX_W-1:0] IDX_SCR   = 'h30,
  parameter logic [IDX_W-1:0] IDX_TICLR = 'h44,
  parameter logic [IDX_W-1:0] IDX_RBADV = 'h89,
  parameter logic [IDX_W-1:0] IDX_RERA  = 'h8a
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instVld,
  input  logic [31:0]      instWord,
  input  logic             userLevel,
  output csrStb_t          stb,
  output logic             resVld,
  output logic             wbEn,
  output logic [REG_W-1:0] wbReg,
  output logic             privTrap,
  output logic             illegalTrap,
  output logic             refetch
);
  logic [OPC_W-1:0] opc;
  logic [IDX_W-1:0] idx, scrOff;
  logic [REG_W-1:0] rjF, rdF;
  logic accepted, isWr, isRo, trapP, trapI, inScr, sideTgt;
  csrTgt_e tgt;

  assign opc    = instWord[OPC_LO +: OPC_W];
  assign idx    = instWord[IDX_LO +: IDX_W];
  assign rjF    = instWord[RJ_LO +: REG_W];
  assign rdF    = instWord[RD_LO +: REG_W];
  assign scrOff = idx - IDX_SCR;
  assign inScr  = (idx >= IDX_SCR) && (scrOff < IDX_W'(NUM_SCR));

  always_comb begin
    tgt = TGT_NONE;
    if      (idx == IDX_CRMD)  tgt = TGT_CRMD;
    else if (idx == IDX_EUEN)  tgt = TGT_EUEN;
    else if (idx == IDX_MISC)  tgt = TGT_MISC;
    else if (idx == IDX_ESTAT) tgt = TGT_ESTAT;
    else if (idx == IDX_BADV)  tgt = TGT_BADV;
    else if (idx == IDX_ASID)  tgt = TGT_ASID;
    else if (idx == IDX_PGDL)  tgt = TGT_PGDL;
    else if (idx == IDX_PGDH)  tgt = TGT_PGDH;
    else if (idx == IDX_PGD)   tgt = TGT_PGD;
    else if (idx == IDX_CPUID) tgt = TGT_CPUID;
    else if (idx == IDX_CFG)   tgt = TGT_CFG;
    else if (idx == IDX_TICLR) tgt = TGT_TICLR;
    else if (idx == IDX_RBADV) tgt = TGT_RBADV;
    else if (idx == IDX_RERA)  tgt = TGT_RERA;
    else if (inScr)            tgt = TGT_SCR;
  end

  assign accepted = instVld && (opc == OPC);
  assign isWr     = (rjF != '0);
  assign isRo     = (tgt == TGT_MISC) || (tgt == TGT_CPUID) ||
                    (tgt == TGT_CFG)  || (tgt == TGT_PGD);
  assign trapP    = accepted && userLevel;
  assign trapI    = accepted && !userLevel && isWr && isRo;
  assign sideTgt  = (tgt == TGT_CRMD) || (tgt == TGT_EUEN) ||
                    (tgt == TGT_ESTAT) || (tgt == TGT_ASID);

  always_comb begin
    stb.go     = accepted && !trapP && !trapI;
    stb.commit = stb.go && isWr && (tgt != TGT_NONE);
    stb.isXchg = (rjF != REG_W'(0)) && (rjF != REG_W'(1));
    stb.tgt    = tgt;
    stb.scrSel = SCR_SEL_W'(scrOff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVld      <= 1'b0;
      wbEn        <= 1'b0;
      wbReg       <= '0;
      privTrap    <= 1'b0;
      illegalTrap <= 1'b0;
      refetch     <= 1'b0;
    end else begin
      resVld      <= accepted;
      wbEn        <= stb.go;
      wbReg       <= accepted ? rdF : '0;
      privTrap    <= trapP;
      illegalTrap <= trapI;
      refetch     <= stb.commit && sideTgt;
    end
  end

  assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (instVld && (instWord[OPC_LO +: OPC_W] != OPC)) |=> !resVld);

  assert_user_trap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (instVld && (instWord[OPC_LO +: OPC_W] == OPC) && userLevel) |=> (privTrap && !wbEn));
endmodule

// File: rtl/csr_dpath.sv
module csr_dpath
  import csr_unit_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          NUM_SCR    = 8,
  parameter int          ESTAT_WR_W = 2,
  parameter int          ASID_WR_W  = 10,
  parameter logic [63:0] CRMD_RST   = 64'h8,
  parameter logic [63:0] ESTAT_RST  = 64'h00A5_0000,
  parameter logic [63:0] ASID_RST   = 64'h000A_0000,
  parameter logic [63:0] MISC_VAL   = 64'h0000_0000_0000_0100,
  parameter logic [63:0] CPUID_VAL  = 64'h0000_0000_0000_0003,
  parameter logic [63:0] CFG_VAL    = 64'h0000_0000_7F00_0008
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrStb_t         stb,
  input  logic [XLEN-1:0] rdVal,
  input  logic [XLEN-1:0] rjVal,
  output logic [XLEN-1:0] wbData,
  output logic            tlbFlush,
  output logic            timerClear
);
  logic [XLEN-1:0] crmdR, euenR, estatR, badvR, asidR, pgdlR, pgdhR, rbadvR, reraR;
  logic [XLEN-1:0] scrR [NUM_SCR];
  logic [XLEN-1:0] oldVal, newVal, scrRd, faultAddr, pgdView, asidNext;
  logic flushNext, clrNext;

  assign faultAddr = reraR[0] ? rbadvR : badvR;
  assign pgdView   = faultAddr[XLEN-1] ? pgdhR : pgdlR;

  always_comb begin
    scrRd = '0;
    for (int i = 0; i < NUM_SCR; i++)
      if (stb.scrSel == SCR_SEL_W'(i)) scrRd = scrR[i];
  end

  always_comb begin
    case (stb.tgt)
      TGT_CRMD:  oldVal = crmdR;
      TGT_EUEN:  oldVal = euenR;
      TGT_ESTAT: oldVal = estatR;
      TGT_BADV:  oldVal = badvR;
      TGT_ASID:  oldVal = asidR;
      TGT_PGDL:  oldVal = pgdlR;
      TGT_PGDH:  oldVal = pgdhR;
      TGT_PGD:   oldVal = pgdView;
      TGT_MISC:  oldVal = XLEN'(MISC_VAL);
      TGT_CPUID: oldVal = XLEN'(CPUID_VAL);
      TGT_CFG:   oldVal = XLEN'(CFG_VAL);
      TGT_RBADV: oldVal = rbadvR;
      TGT_RERA:  oldVal = reraR;
      TGT_SCR:   oldVal = scrRd;
      default:   oldVal = '0;
    endcase
  end

  assign newVal    = stb.isXchg ? ((rdVal & rjVal) | (oldVal & ~rjVal)) : rdVal;
  assign asidNext  = {asidR[XLEN-1:ASID_WR_W], newVal[ASID_WR_W-1:0]};
  assign flushNext = stb.commit && (stb.tgt == TGT_ASID) && (asidNext != asidR);
  assign clrNext   = stb.commit && (stb.tgt == TGT_TICLR) && newVal[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crmdR <= XLEN'(CRMD_RST);
      euenR <= '0;
      estatR <= XLEN'(ESTAT_RST);
      badvR <= '0;
      asidR <= XLEN'(ASID_RST);
      pgdlR <= '0;
      pgdhR <= '0;
      rbadvR <= '0;
      reraR <= '0;
      wbData <= '0;
      tlbFlush <= 1'b0;
      timerClear <= 1'b0;
    end else begin
      wbData     <= stb.go ? oldVal : '0;
      tlbFlush   <= flushNext;
      timerClear <= clrNext;
      if (stb.commit) begin
        case (stb.tgt)
          TGT_CRMD:  crmdR <= newVal;
          TGT_EUEN:  euenR <= newVal;
          TGT_ESTAT: estatR[ESTAT_WR_W-1:0] <= newVal[ESTAT_WR_W-1:0];
          TGT_BADV:  badvR <= newVal;
          TGT_ASID:  asidR <= asidNext;
          TGT_PGDL:  pgdlR <= newVal;
          TGT_PGDH:  pgdhR <= newVal;
          TGT_RBADV: rbadvR <= newVal;
          TGT_RERA:  reraR <= newVal;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) scrR[g] <= '0;
      else if (stb.commit && (stb.tgt == TGT_SCR) && (stb.scrSel == SCR_SEL_W'(g)))
        scrR[g] <= newVal;
    end
  end

  assert_flush_on_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> (asidR != $past(asidR)));

  assert_ack_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    timerClear |-> (wbData == '0));
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_unit_pkg::*;
#(
  parameter int               XLEN       = 64,
  parameter int               IDX_W      = 14,
  parameter int               NUM_SCR    = 8,
  parameter int               ESTAT_WR_W = 2,
  parameter int               ASID_WR_W  = 10,
  parameter logic [7:0]       OPC        = 8'h04,
  parameter logic [IDX_W-1:0] IDX_CRMD   = 'h0,
  parameter logic [IDX_W-1:0] IDX_EUEN   = 'h2,
  parameter logic [IDX_W-1:0] IDX_MISC   = 'h3,
  parameter logic [IDX_W-1:0] IDX_ESTAT  = 'h5,
  parameter logic [IDX_W-1:0] IDX_BADV   = 'h7,
  parameter logic [IDX_W-1:0] IDX_ASID   = 'h18,
  parameter logic [IDX_W-1:0] IDX_PGDL   = 'h19,
  parameter logic [IDX_W-1:0] IDX_PGDH   = 'h1a,
  parameter logic [IDX_W-1:0] IDX_PGD    = 'h1b,
  parameter logic [IDX_W-1:0] IDX_CPUID  = 'h20,
  parameter logic [IDX_W-1:0] IDX_CFG    = 'h21,
  parameter logic [IDX_W-1:0] IDX_SCR    = 'h30,
  parameter logic [IDX_W-1:0] IDX_TICLR  = 'h44,
  parameter logic [IDX_W-1:0] IDX_RBADV  = 'h89,
  parameter logic [IDX_W-1:0] IDX_RERA   = 'h8a,
  parameter logic [63:0]      CRMD_RST   = 64'h8,
  parameter logic [63:0]      ESTAT_RST  = 64'h00A5_0000,
  parameter logic [63:0]      ASID_RST   = 64'h000A_0000,
  parameter logic [63:0]      MISC_VAL   = 64'h0000_0000_0000_0100,
  parameter logic [63:0]      CPUID_VAL  = 64'h0000_0000_0000_0003,
  parameter logic [63:0]      CFG_VAL    = 64'h0000_0000_7F00_0008
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instVld,
  input  logic [31:0]     instWord,
  input  logic            userLevel,
  input  logic [XLEN-1:0] rdVal,
  input  logic [XLEN-1:0] rjVal,
  output logic            resVld,
  output logic            wbEn,
  output logic [4:0]      wbReg,
  output logic [XLEN-1:0] wbData,
  output logic            privTrap,
  output logic            illegalTrap,
  output logic            tlbFlush,
  output logic            timerClear,
  output logic            refetch
);
  csrStb_t stb;

  csr_ctrl #(
    .IDX_W(IDX_W), .NUM_SCR(NUM_SCR), .OPC(OPC),
    .IDX_CRMD(IDX_CRMD), .IDX_EUEN(IDX_EUEN), .IDX_MISC(IDX_MISC),
    .IDX_ESTAT(IDX_ESTAT), .IDX_BADV(IDX_BADV), .IDX_ASID(IDX_ASID),
    .IDX_PGDL(IDX_PGDL), .IDX_PGDH(IDX_PGDH), .IDX_PGD(IDX_PGD),
    .IDX_CPUID(IDX_CPUID), .IDX_CFG(IDX_CFG), .IDX_SCR(IDX_SCR),
    .IDX_TICLR(IDX_TICLR), .IDX_RBADV(IDX_RBADV), .IDX_RERA(IDX_RERA)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .instVld(instVld), .instWord(instWord),
    .userLevel(userLevel), .stb(stb), .resVld(resVld), .wbEn(wbEn),
    .wbReg(wbReg), .privTrap(privTrap), .illegalTrap(illegalTrap),
    .refetch(refetch)
  );

  csr_dpath #(
    .XLEN(XLEN), .NUM_SCR(NUM_SCR), .ESTAT_WR_W(ESTAT_WR_W),
    .ASID_WR_W(ASID_WR_W), .CRMD_RST(CRMD_RST), .ESTAT_RST(ESTAT_RST),
    .ASID_RST(ASID_RST), .MISC_VAL(MISC_VAL), .CPUID_VAL(CPUID_VAL),
    .CFG_VAL(CFG_VAL)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rdVal(rdVal), .rjVal(rjVal),
    .wbData(wbData), .tlbFlush(tlbFlush), .timerClear(timerClear)
  );

  assert_trap_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    (privTrap || illegalTrap) |-> (!wbEn && !tlbFlush && !timerClear && !refetch));

  assert_pulse_qualified_R12: assert property (@(posedge clk) disable iff (!rstN)
    (tlbFlush || timerClear || refetch) |-> (resVld && wbEn));
endmodule

// File: tb/test_csr_access_unit.sv
module test_csr_access_unit;
  localparam logic [7:0]  OPC   = 8'h04;
  localparam logic [13:0] K_CRMD = 14'h0, K_EUEN = 14'h2, K_MISC = 14'h3,
                          K_ESTAT = 14'h5, K_BADV = 14'h7, K_ASID = 14'h18,
                          K_PGDL = 14'h19, K_PGDH = 14'h1a, K_PGD = 14'h1b,
                          K_CPUID = 14'h20, K_CFG = 14'h21, K_SCR = 14'h30,
                          K_TICLR = 14'h44, K_RBADV = 14'h89, K_RERA = 14'h8a;
  localparam int          NSCR = 8;
  localparam logic [63:0] V_CRMD = 64'h8, V_ESTAT = 64'h00A5_0000,
                          V_ASID = 64'h000A_0000, V_MISC = 64'h100,
                          V_CPUID = 64'h3, V_CFG = 64'h7F00_0008;
  localparam logic [4:0]  RD = 5'd0, WR = 5'd1, XC = 5'd9;

  logic clk = 0, rstN = 0, instVld = 0, userLevel = 0;
  logic [31:0] instWord = '0;
  logic [63:0] rdVal = '0, rjVal = '0;
  logic resVld, wbEn, privTrap, illegalTrap, tlbFlush, timerClear, refetch;
  logic [4:0] wbReg;
  logic [63:0] wbData;

  always #5 clk = ~clk;

  csr_access_unit #(
    .OPC(OPC), .IDX_CRMD(K_CRMD), .IDX_EUEN(K_EUEN), .IDX_MISC(K_MISC),
    .IDX_ESTAT(K_ESTAT), .IDX_BADV(K_BADV), .IDX_ASID(K_ASID),
    .IDX_PGDL(K_PGDL), .IDX_PGDH(K_PGDH), .IDX_PGD(K_PGD),
    .IDX_CPUID(K_CPUID), .IDX_CFG(K_CFG), .IDX_SCR(K_SCR),
    .IDX_TICLR(K_TICLR), .IDX_RBADV(K_RBADV), .IDX_RERA(K_RERA),
    .NUM_SCR(NSCR), .CRMD_RST(V_CRMD), .ESTAT_RST(V_ESTAT),
    .ASID_RST(V_ASID), .MISC_VAL(V_MISC), .CPUID_VAL(V_CPUID), .CFG_VAL(V_CFG)
  ) i_csr_access_unit (
    .clk(clk), .rstN(rstN), .instVld(instVld), .instWord(instWord),
    .userLevel(userLevel), .rdVal(rdVal), .rjVal(rjVal), .resVld(resVld),
    .wbEn(wbEn), .wbReg(wbReg), .wbData(wbData), .privTrap(privTrap),
    .illegalTrap(illegalTrap), .tlbFlush(tlbFlush), .timerClear(timerClear),
    .refetch(refetch)
  );

  typedef struct {
    logic        wbEn;
    logic [63:0] data;
    logic        priv, ill, flush, tclr, refetch;
    string       req;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, fails = 0;
  bit running = 0, done = 0;

  // bench-side model of the register file
  logic [63:0] mCrmd, mEuen, mEstat, mBadv, mAsid, mPgdl, mPgdh, mRbadv, mRera;
  logic [63:0] mScr [NSCR];

  function automatic bit inScr(logic [13:0] idx);
    return (idx >= K_SCR) && (idx < K_SCR + 14'(NSCR));
  endfunction

  function automatic bit mRo(logic [13:0] idx);
    return idx == K_MISC || idx == K_CPUID || idx == K_CFG || idx == K_PGD;
  endfunction

  function automatic bit mDefined(logic [13:0] idx);
    return mRo(idx) || inScr(idx) || idx == K_CRMD || idx == K_EUEN ||
           idx == K_ESTAT || idx == K_BADV || idx == K_ASID || idx == K_PGDL ||
           idx == K_PGDH || idx == K_TICLR || idx == K_RBADV || idx == K_RERA;
  endfunction

  function automatic logic [63:0] mRead(logic [13:0] idx);
    logic [63:0] fa;
    fa = mRera[0] ? mRbadv : mBadv;
    if (inScr(idx)) return mScr[idx - K_SCR];
    case (idx)
      K_CRMD: return mCrmd;   K_EUEN: return mEuen;
      K_ESTAT: return mEstat; K_BADV: return mBadv;
      K_ASID: return mAsid;   K_PGDL: return mPgdl;
      K_PGDH: return mPgdh;   K_PGD: return fa[63] ? mPgdh : mPgdl;
      K_MISC: return V_MISC;  K_CPUID: return V_CPUID;
      K_CFG: return V_CFG;    K_RBADV: return mRbadv;
      K_RERA: return mRera;
      default: return 64'h0;
    endcase
  endfunction

  task automatic mWrite(input logic [13:0] idx, input logic [63:0] nv, inout exp_t e);
    logic [63:0] nx;
    if (inScr(idx)) mScr[idx - K_SCR] = nv;
    case (idx)
      K_CRMD:  begin mCrmd = nv; e.refetch = 1; end
      K_EUEN:  begin mEuen = nv; e.refetch = 1; end
      K_ESTAT: begin mEstat[1:0] = nv[1:0]; e.refetch = 1; end
      K_ASID:  begin
        nx = {mAsid[63:10], nv[9:0]};
        e.flush = (nx != mAsid); mAsid = nx; e.refetch = 1;
      end
      K_BADV:  mBadv = nv;
      K_PGDL:  mPgdl = nv;
      K_PGDH:  mPgdh = nv;
      K_RBADV: mRbadv = nv;
      K_RERA:  mRera = nv;
      K_TICLR: e.tclr = nv[0];
      default: ;
    endcase
  endtask

  task automatic fail(input string msg);
    fails++;
    $display("FAIL %s", msg);
  endtask

  // driver: drives one instruction word for one cycle, pushes the expectation
  task automatic issue(input logic [7:0] opc, input logic [13:0] idx,
                       input logic [4:0] rjF, input logic usr,
                       input logic [63:0] rdv, input logic [63:0] rjv,
                       input string req);
    exp_t e;
    logic [63:0] oldv, newv;
    instVld = 1; instWord = {opc, idx, rjF, 5'd7};
    userLevel = usr; rdVal = rdv; rjVal = rjv;
    if (opc == OPC) begin
      e.wbEn = 0; e.data = 0; e.priv = 0; e.ill = 0;
      e.flush = 0; e.tclr = 0; e.refetch = 0; e.req = req;
      if (usr) e.priv = 1;
      else if (rjF != 0 && mRo(idx)) e.ill = 1;
      else begin
        oldv = mRead(idx);
        e.wbEn = 1; e.data = oldv;
        if (rjF != 0 && mDefined(idx)) begin
          newv = (rjF == 1) ? rdv : ((rdv & rjv) | (oldv & ~rjv));
          mWrite(idx, newv, e);
        end
      end
      expQ.push_back(e);
    end
    @(negedge clk);
    if (opc != OPC) begin
      checks++;
      if (resVld !== 1'b0) fail($sformatf("%s foreign word: resVld=%b expected 0", req, resVld));
    end
  endtask

  task automatic idle(input int n);
    instVld = 0; userLevel = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (running) begin
      if (resVld) begin
        checks++;
        if (expQ.size() == 0) fail("R1 result with no issued instruction: resVld=1 expected 0");
        else begin
          e = expQ.pop_front();
          if ({wbEn, wbData, privTrap, illegalTrap, tlbFlush, timerClear, refetch, wbReg} !==
              {e.wbEn, e.data, e.priv, e.ill, e.flush, e.tclr, e.refetch, 5'd7})
            fail($sformatf("%s: got wbEn=%b data=%h priv=%b ill=%b flush=%b clr=%b refetch=%b reg=%0d, exp wbEn=%b data=%h priv=%b ill=%b flush=%b clr=%b refetch=%b reg=7",
              e.req, wbEn, wbData, privTrap, illegalTrap, tlbFlush, timerClear, refetch, wbReg,
              e.wbEn, e.data, e.priv, e.ill, e.flush, e.tclr, e.refetch));
        end
      end else if (wbEn || privTrap || illegalTrap || tlbFlush || timerClear || refetch) begin
        checks++;
        fail($sformatf("R12 output without result: wbEn=%b priv=%b ill=%b flush=%b clr=%b refetch=%b expected all 0",
             wbEn, privTrap, illegalTrap, tlbFlush, timerClear, refetch));
      end
    end
  end

  initial begin
    int cnt;
    cnt = 0;
    while (!done && cnt < 20000) begin @(posedge clk); cnt++; end
    if (!done) begin
      checks++;
      fail("R12 watchdog expired: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    mCrmd = V_CRMD; mEuen = 0; mEstat = V_ESTAT; mBadv = 0; mAsid = V_ASID;
    mPgdl = 0; mPgdh = 0; mRbadv = 0; mRera = 0;
    for (int i = 0; i < NSCR; i++) mScr[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if ({resVld, wbEn, wbData, privTrap, illegalTrap, tlbFlush, timerClear, refetch} !== '0)
      fail($sformatf("R13 reset outputs: resVld=%b wbEn=%b data=%h expected all 0", resVld, wbEn, wbData));
    running = 1;

    issue(OPC, K_CRMD, RD, 0, 0, 0, "R13 mode reset value");
    issue(OPC, K_ESTAT, RD, 0, 0, 0, "R13 status reset value");
    issue(OPC, K_ASID, RD, 0, 0, 0, "R13 identifier reset value");
    // R5 write
    issue(OPC, K_SCR, WR, 0, 64'h1122_3344_5566_7788, 0, "R5 write returns old");
    issue(OPC, K_SCR, RD, 0, 0, 0, "R5 write stored");
    issue(OPC, K_SCR + 3, WR, 0, 64'hDEAD_BEEF_0000_0001, 0, "R5 write scratch3");
    // R6 exchange
    issue(OPC, K_SCR, XC, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h00FF_00FF_00FF_00FF, "R6 merge");
    issue(OPC, K_SCR, RD, 0, 0, 0, "R6 merge stored");
    issue(OPC, K_SCR + 3, 5'd31, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6 zero mask");
    issue(OPC, K_SCR + 3, RD, 0, 0, 0, "R6 zero mask keeps");
    // R3 undefined
    issue(OPC, 14'h1234, WR, 0, 64'h55, 0, "R3 undefined write");
    issue(OPC, 14'h1234, RD, 0, 0, 0, "R3 undefined read");
    issue(OPC, 14'h3FFF, XC, 0, 64'h1, 64'h1, "R3 undefined exchange");
    issue(OPC, K_SCR + 8, WR, 0, 64'h77, 0, "R3 one past scratch");
    issue(OPC, K_SCR + 7, RD, 0, 0, 0, "R3 last scratch untouched");
    // R4 read-only
    issue(OPC, K_MISC, WR, 0, 64'h99, 0, "R4 write misc traps");
    issue(OPC, K_MISC, RD, 0, 0, 0, "R4 misc read");
    issue(OPC, K_PGD, XC, 0, 64'h1, 64'h1, "R4 exchange view traps");
    issue(OPC, K_CPUID, RD, 0, 0, 0, "R4 id read");
    issue(OPC, K_CFG, WR, 0, 0, 0, "R4 feature write traps");
    issue(OPC, K_CFG, RD, 0, 0, 0, "R4 feature read");
    // R2 user level
    issue(OPC, K_SCR + 1, WR, 1, 64'h1234, 0, "R2 user write traps");
    issue(OPC, K_SCR + 1, RD, 1, 0, 0, "R2 user read traps");
    issue(OPC, K_TICLR, WR, 1, 64'h1, 0, "R2 user ack no pulse");
    issue(OPC, K_ASID, WR, 1, 64'h3FF, 0, "R2 user identifier no flush");
    issue(OPC, K_SCR + 1, RD, 0, 0, 0, "R2 scratch unchanged");
    issue(OPC, K_ASID, RD, 0, 0, 0, "R2 identifier unchanged");
    // R7 status
    issue(OPC, K_ESTAT, WR, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R7 status write");
    issue(OPC, K_ESTAT, RD, 0, 0, 0, "R7 status low bits only");
    issue(OPC, K_ESTAT, XC, 0, 64'h0, 64'h1, "R7 status exchange");
    issue(OPC, K_ESTAT, RD, 0, 0, 0, "R7 status after exchange");
    // R8 identifier, back to back (R12)
    issue(OPC, K_ASID, WR, 0, 64'hFFFF_FC00, 0, "R8 same low bits no flush");
    issue(OPC, K_ASID, WR, 0, 64'h155, 0, "R8 change flushes");
    issue(OPC, K_ASID, WR, 0, 64'h155, 0, "R8 R12 repeat no flush");
    issue(OPC, K_ASID, XC, 0, 64'h0, 64'h3, "R8 exchange change flushes");
    issue(OPC, K_ASID, RD, 0, 0, 0, "R8 identifier value");
    // R9 page-directory view
    issue(OPC, K_BADV, WR, 0, 64'h8000_0000_0000_0010, 0, "R9 setup");
    issue(OPC, K_PGDL, WR, 0, 64'h1000, 0, "R9 setup");
    issue(OPC, K_PGDH, WR, 0, 64'h2000, 0, "R9 setup");
    issue(OPC, K_PGD, RD, 0, 0, 0, "R9 bad address high half");
    issue(OPC, K_RBADV, WR, 0, 64'h40, 0, "R9 setup");
    issue(OPC, K_RERA, WR, 0, 64'h1, 0, "R9 setup");
    issue(OPC, K_PGD, RD, 0, 0, 0, "R9 refill address low half");
    issue(OPC, K_RBADV, WR, 0, 64'h8000_0000_0000_0040, 0, "R9 setup");
    issue(OPC, K_PGD, RD, 0, 0, 0, "R9 refill address high half");
    issue(OPC, K_RERA, WR, 0, 64'h2, 0, "R9 setup");
    issue(OPC, K_BADV, WR, 0, 64'h10, 0, "R9 setup");
    issue(OPC, K_PGD, RD, 0, 0, 0, "R9 bad address low half");
    // R10 timer acknowledge
    issue(OPC, K_TICLR, WR, 0, 64'h1, 0, "R10 ack pulses");
    issue(OPC, K_TICLR, WR, 0, 64'h2, 0, "R10 bit0 clear no pulse");
    issue(OPC, K_TICLR, RD, 0, 0, 0, "R10 reads zero");
    issue(OPC, K_TICLR, XC, 0, 64'h1, 64'h1, "R10 exchange pulses");
    issue(OPC, K_TICLR, XC, 0, 64'h1, 64'h2, "R10 masked exchange no pulse");
    // R11 refetch
    issue(OPC, K_CRMD, WR, 0, 64'h3, 0, "R11 mode write refetch");
    issue(OPC, K_CRMD, RD, 0, 0, 0, "R11 mode read no refetch");
    issue(OPC, K_EUEN, XC, 0, 64'h1, 64'h1, "R11 enable exchange refetch");
    issue(OPC, K_BADV, WR, 0, 64'h4, 0, "R11 other write no refetch");
    // R1 foreign words
    issue(8'h05, K_SCR + 2, WR, 0, 64'hBAD, 0, "R1");
    issue(8'h00, K_CRMD, WR, 0, 64'hBAD, 0, "R1");
    idle(1);
    issue(OPC, K_SCR + 2, RD, 0, 0, 0, "R1 foreign left scratch");
    issue(OPC, K_CRMD, RD, 0, 0, 0, "R1 foreign left mode");
    idle(3);
    checks++;
    if (expQ.size() != 0) fail($sformatf("R12 results missing: %0d pending expected 0", expQ.size()));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule